// File: doc/BRIEF.md
# Disk Device DMA Sector Data Port

This block is the device-side data path for multiword DMA on a parallel disk interface. It sits between the host-facing data lines and a one-sector byte buffer. A sector sequencer, which owns the storage medium, fills that buffer for reads and drains it for writes. The port accepts two DMA commands, a read and a write. It raises the DMA request while the buffer is ready to be moved. It moves 16-bit words only when the full handshake qualifies them. It packs each word into two buffer bytes, or unpacks two bytes into a word.

On a read command the port first asks the sequencer to load a sector, holding busy until the sequencer acknowledges. It then requests DMA until the host has emptied the buffer, and repeats this for each remaining sector. On a write command it requests data at once. Once the buffer is full it hands the sector to the sequencer for commit, and it resumes while sectors remain. A sequencer failure ends the command with an error. The last sector, or an error, raises the interrupt line.

Top module: `atadev_dma_port`

## Requirements
- R1: After synchronous reset, dmarq, drq, bsy, err, irq and xfer_req are 0, err_code is 0x00 and rd_data reads 0xFFFF.
- R2: A word moves only when dev_sel, dmack and dmarq are high, bsy is low, drq is high, and the strobe matches the command direction (rd_stb for a read command, wr_stb for a write command).
- R3: A read strobe that is not accepted gives rd_data = 0xFFFF in the next cycle. A write strobe that is not accepted changes neither the buffer nor the word pointer. In both cases the next accepted word lands on the same buffer position it would have used.
- R4: Word k of a sector occupies buffer bytes 2k (bits 7:0) and 2k+1 (bits 15:8), and the pointer steps by one word per accepted transfer. Read data appears on rd_data in the cycle after the accepted strobe. The sequencer port reads a byte one cycle after it presents the address.
- R5: Opcode 0xCA (write DMA), accepted in idle, sets drq and dmarq with bsy low in the next cycle.
- R6: Opcode 0xC8 (read DMA) sets bsy and xfer_req with xfer_wr = 0 in the next cycle. dmarq stays low until the sequencer pulses xfer_ack with xfer_ok = 1, and is high in the cycle after that pulse.
- R7: When a read takes the last word of the buffer, dmarq and drq drop in the next cycle and the pointer returns to word 0. If sectors remain, a new load request (bsy, xfer_req, xfer_wr = 0) follows in that same cycle.
- R8: When a write fills the buffer, dmarq and drq drop in the next cycle, and bsy, xfer_req and xfer_wr rise. The sequencer can then read the written bytes.
- R9: The remaining-sector count loads from cmd_count, where 0 means 256, and falls by one per completed sector. When it reaches zero the port goes idle with drq low and irq high; irq stays low before then.
- R10: xfer_ack with xfer_ok = 0 sets err, loads err_code = 0x80 and raises irq. In the next cycle the port is idle with bsy and drq low.
- R11: Any opcode other than 0xC8 or 0xCA, and any command issued while not idle, has no effect. An accepted command clears err, err_code and irq.
- R12: xfer_req stays high until the cycle in which xfer_ack is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_sel | input | 1 | This device is the one addressed on the bus |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| cmd_count | input | CNT_W | Sector count, 0 means 2^CNT_W |
| dmack | input | 1 | Host DMA acknowledge |
| rd_stb | input | 1 | Host word read strobe |
| wr_stb | input | 1 | Host word write strobe |
| wr_data | input | 16 | Host write word |
| rd_data | output | 16 | Host read word, 0xFFFF when nothing was accepted |
| dmarq | output | 1 | DMA request |
| drq | output | 1 | Data request status |
| bsy | output | 1 | Busy status |
| err | output | 1 | Error status |
| err_code | output | 8 | Error code, 0x80 for a failed sector |
| irq | output | 1 | Interrupt request |
| xfer_req | output | 1 | Sector hand-off request to sequencer |
| xfer_wr | output | 1 | 1 = commit buffer to medium, 0 = load buffer |
| xfer_ack | input | 1 | Sequencer completion pulse |
| xfer_ok | input | 1 | Sequencer result with xfer_ack |
| seq_addr | input | log2(BUF_BYTES) | Sequencer byte address |
| seq_we | input | 1 | Sequencer byte write |
| seq_wdata | input | 8 | Sequencer write byte |
| seq_rdata | output | 8 | Sequencer read byte |

## Verification
The hardest states to reach are a rejected strobe in the middle of a sector and a count of zero, which only shows its effect after 256 sector round trips. The bench shrinks the buffer to eight words. With that size it runs the full 256-sector read and checks that irq stays low until the final word. It also drops dev_sel or dmack between accepted words and confirms that the following words still arrive in order. The sequencer side is modelled in the bench, which holds the acknowledge back to test the request hold and returns failures on both the load path and the commit path.

// File: rtl/atadev_dma_pkg.sv
package atadev_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_XFER   = 2'd2,
    ST_COMMIT = 2'd3
  } dma_st_e;

  localparam logic [7:0] OP_RD_DMA      = 8'hC8;
  localparam logic [7:0] OP_WR_DMA      = 8'hCA;
  localparam logic [7:0] ERR_BAD_SECTOR = 8'h80;
endpackage

// File: rtl/atadev_byte_ram.sv
module atadev_byte_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    q
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/atadev_dma_fsm.sv
module atadev_dma_fsm
  import atadev_dma_pkg::*;
#(
  parameter int WORDS = 256,
  parameter int CNT_W = 8,
  parameter int WAW   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_op,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             dev_sel,
  input  logic             dmack,
  input  logic             rd_stb,
  input  logic             wr_stb,
  input  logic             xfer_ack,
  input  logic             xfer_ok,
  output logic [WAW-1:0]   wptr,
  output logic             rd_acc,
  output logic             wr_acc,
  output logic             dmarq,
  output logic             drq,
  output logic             bsy,
  output logic             err,
  output logic [7:0]       err_code,
  output logic             irq,
  output logic             xfer_req,
  output logic             xfer_wr
);
  dma_st_e          st;
  logic             is_rd;
  logic [CNT_W:0]   rem;
  logic             qual, last_word, rem_last, cmd_known;

  assign drq      = (st == ST_XFER);
  assign dmarq    = (st == ST_XFER);
  assign bsy      = (st == ST_LOAD) || (st == ST_COMMIT);
  assign xfer_req = bsy;
  assign xfer_wr  = (st == ST_COMMIT);

  assign qual      = dev_sel && dmack && dmarq && drq && !bsy;
  assign rd_acc    = qual && rd_stb && is_rd;
  assign wr_acc    = qual && wr_stb && !is_rd;
  assign last_word = (wptr == WAW'(WORDS - 1));
  assign rem_last  = (rem == (CNT_W+1)'(1));
  assign cmd_known = (cmd_op == OP_RD_DMA) || (cmd_op == OP_WR_DMA);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      is_rd    <= 1'b0;
      wptr     <= '0;
      rem      <= '0;
      err      <= 1'b0;
      err_code <= '0;
      irq      <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (cmd_valid && cmd_known) begin
            is_rd    <= (cmd_op == OP_RD_DMA);
            wptr     <= '0;
            rem      <= (cmd_count == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cmd_count};
            err      <= 1'b0;
            err_code <= '0;
            irq      <= 1'b0;
            st       <= (cmd_op == OP_RD_DMA) ? ST_LOAD : ST_XFER;
          end
        end
        ST_XFER: begin
          if (rd_acc || wr_acc) begin
            if (last_word) begin
              wptr <= '0;
              if (is_rd) begin
                rem <= rem - 1'b1;
                if (rem_last) begin
                  st  <= ST_IDLE;
                  irq <= 1'b1;
                end else begin
                  st <= ST_LOAD;
                end
              end else begin
                st <= ST_COMMIT;
              end
            end else begin
              wptr <= wptr + 1'b1;
            end
          end
        end
        ST_LOAD, ST_COMMIT: begin
          if (xfer_ack) begin
            if (!xfer_ok) begin
              err      <= 1'b1;
              err_code <= ERR_BAD_SECTOR;
              irq      <= 1'b1;
              st       <= ST_IDLE;
            end else if (st == ST_LOAD) begin
              st <= ST_XFER;
            end else begin
              rem <= rem - 1'b1;
              if (rem_last) begin
                st  <= ST_IDLE;
                irq <= 1'b1;
              end else begin
                st <= ST_XFER;
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/atadev_dma_port.sv
module atadev_dma_port
  import atadev_dma_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  parameter int CNT_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         dev_sel,
  input  logic                         cmd_valid,
  input  logic [7:0]                   cmd_op,
  input  logic [CNT_W-1:0]             cmd_count,
  input  logic                         dmack,
  input  logic                         rd_stb,
  input  logic                         wr_stb,
  input  logic [15:0]                  wr_data,
  output logic [15:0]                  rd_data,
  output logic                         dmarq,
  output logic                         drq,
  output logic                         bsy,
  output logic                         err,
  output logic [7:0]                   err_code,
  output logic                         irq,
  output logic                         xfer_req,
  output logic                         xfer_wr,
  input  logic                         xfer_ack,
  input  logic                         xfer_ok,
  input  logic [$clog2(BUF_BYTES)-1:0] seq_addr,
  input  logic                         seq_we,
  input  logic [7:0]                   seq_wdata,
  output logic [7:0]                   seq_rdata
);
  localparam int WORDS = BUF_BYTES / 2;
  localparam int WAW   = $clog2(WORDS);
  localparam int BAW   = $clog2(BUF_BYTES);

  logic [WAW-1:0] wptr;
  logic           rd_acc, wr_acc;
  logic           rd_ok_q, seq_hi_q;
  logic [7:0]     lane_q [2];

  atadev_dma_fsm #(.WORDS(WORDS), .CNT_W(CNT_W)) u_fsm (
    .clk, .rst, .cmd_valid, .cmd_op, .cmd_count, .dev_sel, .dmack,
    .rd_stb, .wr_stb, .xfer_ack, .xfer_ok, .wptr, .rd_acc, .wr_acc,
    .dmarq, .drq, .bsy, .err, .err_code, .irq, .xfer_req, .xfer_wr
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic           we_g;
    logic [WAW-1:0] a_g;
    logic [7:0]     d_g;
    always_comb begin
      if (drq) begin
        we_g = wr_acc;
        a_g  = wptr;
        d_g  = wr_data[8*g +: 8];
      end else begin
        we_g = seq_we && (seq_addr[0] == 1'(g));
        a_g  = seq_addr[BAW-1:1];
        d_g  = seq_wdata;
      end
    end
    atadev_byte_ram #(.DEPTH(WORDS)) u_ram (
      .clk, .we(we_g), .addr(a_g), .wdata(d_g), .q(lane_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ok_q  <= 1'b0;
      seq_hi_q <= 1'b0;
    end else begin
      rd_ok_q  <= rd_acc;
      seq_hi_q <= seq_addr[0];
    end
  end

  assign rd_data   = rd_ok_q ? {lane_q[1], lane_q[0]} : 16'hFFFF;
  assign seq_rdata = seq_hi_q ? lane_q[1] : lane_q[0];
endmodule

// File: rtl/atadev_dma_port_chk.sv
module atadev_dma_port_chk #(
  parameter int WAW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           cmd_valid,
  input logic           dev_sel,
  input logic           dmack,
  input logic           rd_stb,
  input logic [15:0]    rd_data,
  input logic           dmarq,
  input logic           drq,
  input logic           bsy,
  input logic           err,
  input logic [7:0]     err_code,
  input logic           irq,
  input logic           xfer_req,
  input logic           xfer_ack,
  input logic [WAW-1:0] wptr
);
  a_r3_reject_read_ones: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !dmack) |=> (rd_data == 16'hFFFF));

  a_r2_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    (!(dmack && dev_sel && dmarq) && !cmd_valid) |=> $stable(wptr));

  a_r8_handoff_excl: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> (!dmarq && bsy));

  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_ack) |=> xfer_req);

  a_r10_err_irq: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (irq && err_code == 8'h80));

  a_r5_drq_not_busy: assert property (@(posedge clk) disable iff (rst)
    drq |-> !bsy);
endmodule

bind atadev_dma_port atadev_dma_port_chk #(.WAW(WAW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .dev_sel(dev_sel),
  .dmack(dmack), .rd_stb(rd_stb), .rd_data(rd_data), .dmarq(dmarq),
  .drq(drq), .bsy(bsy), .err(err), .err_code(err_code), .irq(irq),
  .xfer_req(xfer_req), .xfer_ack(xfer_ack), .wptr(wptr)
);

// File: tb/tb_atadev_dma_port.sv
module tb_atadev_dma_port;
  localparam int BUF_BYTES = 16;
  localparam int WORDS     = BUF_BYTES / 2;
  localparam int CNT_W     = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic dev_sel = 1'b1, cmd_valid = 1'b0, dmack = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0] cmd_op = '0;
  logic [CNT_W-1:0] cmd_count = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic dmarq, drq, bsy, err, irq, xfer_req, xfer_wr;
  logic [7:0] err_code, seq_wdata = '0, seq_rdata;
  logic xfer_ack = 1'b0, xfer_ok = 1'b0, seq_we = 1'b0;
  logic [$clog2(BUF_BYTES)-1:0] seq_addr = '0;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  atadev_dma_port #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) dut (
    .clk, .rst, .dev_sel, .cmd_valid, .cmd_op, .cmd_count, .dmack, .rd_stb,
    .wr_stb, .wr_data, .rd_data, .dmarq, .drq, .bsy, .err, .err_code, .irq,
    .xfer_req, .xfer_wr, .xfer_ack, .xfer_ok, .seq_addr, .seq_we, .seq_wdata,
    .seq_rdata
  );

  function automatic logic [15:0] wpat(int s, int k);
    return {8'(s * 16 + k), 8'(k * 3 + s + 1)};
  endfunction
  function automatic logic [7:0] bpat(int s, int i);
    return 8'(s * 29 + i * 7 + 3);
  endfunction

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input int cnt);
    cmd_valid = 1'b1; cmd_op = op; cmd_count = CNT_W'(cnt);
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic hwrite(input logic [15:0] w);
    dmack = 1'b1; wr_stb = 1'b1; wr_data = w;
    tick();
    dmack = 1'b0; wr_stb = 1'b0;
  endtask

  task automatic hread(output logic [15:0] w);
    dmack = 1'b1; rd_stb = 1'b1;
    tick();
    w = rd_data; dmack = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic fill(input int s);
    for (int i = 0; i < BUF_BYTES; i++) begin
      seq_we = 1'b1; seq_addr = 4'(i); seq_wdata = bpat(s, i);
      tick();
    end
    seq_we = 1'b0;
  endtask

  task automatic ack(input logic ok);
    xfer_ack = 1'b1; xfer_ok = ok;
    tick();
    xfer_ack = 1'b0; xfer_ok = 1'b0;
  endtask

  task automatic check_commit(input int s);
    logic [15:0] w;
    for (int i = 0; i < BUF_BYTES; i++) begin
      seq_addr = 4'(i);
      tick();
      w = wpat(s, i / 2);
      chk("R4 R8 committed byte", seq_rdata, (i % 2) ? w[15:8] : w[7:0]);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    bit early;
    @(negedge clk); tick(); rst = 1'b0; tick();

    // R1 reset state
    chk("R1 outputs", {dmarq, drq, bsy, err, irq, xfer_req}, 6'b0);
    chk("R1 err_code", err_code, 8'h00);
    chk("R1 rd_data", rd_data, 16'hFFFF);

    // R11 unknown opcode ignored
    issue(8'h20, 1);
    chk("R11 unknown opcode", {dmarq, drq, bsy, xfer_req}, 4'b0);

    // R5 write command
    issue(8'hCA, 2);
    chk("R5 drq/dmarq/bsy", {drq, dmarq, bsy}, 3'b110);

    // R2 R3 rejected writes and wrong-direction read
    dev_sel = 1'b0; hwrite(16'hDEAD); dev_sel = 1'b1;
    wr_stb = 1'b1; wr_data = 16'hBEEF; tick(); wr_stb = 1'b0;
    hread(w);
    chk("R2 read in write cmd", w, 16'hFFFF);

    for (int k = 0; k < WORDS; k++) hwrite(wpat(0, k));
    chk("R8 full handoff", {dmarq, drq, bsy, xfer_req, xfer_wr}, 5'b00111);
    hwrite(16'h1234);
    issue(8'hC8, 1);
    chk("R11 cmd while busy", {xfer_req, xfer_wr}, 2'b11);
    tick(); tick();
    chk("R12 req held", xfer_req, 1'b1);
    check_commit(0);
    ack(1'b1);
    chk("R9 continue after commit", {drq, dmarq, irq}, 3'b110);
    for (int k = 0; k < WORDS; k++) hwrite(wpat(1, k));
    check_commit(1);
    ack(1'b1);
    chk("R9 write final", {irq, drq, bsy, dmarq}, 4'b1000);

    // R6 read command
    issue(8'hC8, 3);
    chk("R6 load req", {bsy, xfer_req, xfer_wr, dmarq}, 4'b1100);
    chk("R11 irq cleared", irq, 1'b0);
    hread(w);
    chk("R2 read without dmarq", w, 16'hFFFF);
    chk("R6 dmarq still low", dmarq, 1'b0);
    for (int s = 0; s < 3; s++) begin
      fill(s);
      ack(1'b1);
      chk("R6 dmarq after ack", {dmarq, drq, bsy}, 3'b110);
      for (int k = 0; k < WORDS; k++) begin
        hread(w);
        chk("R4 read word", w, {bpat(s, 2 * k + 1), bpat(s, 2 * k)});
        if (k == 3) begin
          dev_sel = 1'b0; hread(w); dev_sel = 1'b1;
          chk("R3 rejected read", w, 16'hFFFF);
        end
      end
      if (s < 2) chk("R7 next load", {dmarq, drq, bsy, xfer_req, xfer_wr, irq}, 6'b001100);
      else chk("R7 R9 read final", {dmarq, drq, bsy, irq}, 4'b0001);
    end

    // R10 commit failure
    issue(8'hCA, 1);
    for (int k = 0; k < WORDS; k++) hwrite(wpat(2, k));
    ack(1'b0);
    chk("R10 commit fail", {err, irq, bsy, drq, dmarq}, 5'b11000);
    chk("R10 err_code", err_code, 8'h80);
    issue(8'h20, 1);
    chk("R11 unknown keeps err", err, 1'b1);
    issue(8'hC8, 1);
    chk("R11 cmd clears err", {err, irq}, 2'b00);
    chk("R11 cmd clears code", err_code, 8'h00);
    ack(1'b0);
    chk("R10 load fail", {err, irq, bsy, dmarq}, 4'b1100);

    // R9 count 0 means 256 sectors
    issue(8'hC8, 0);
    early = 1'b0;
    for (int s = 0; s < 256; s++) begin
      ack(1'b1);
      for (int k = 0; k < WORDS; k++) hread(w);
      if (s < 255 && irq) early = 1'b1;
    end
    chk("R9 no early irq", early, 1'b0);
    chk("R9 256 sectors done", {irq, bsy, drq}, 3'b100);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule